// File: doc/BRIEF.md
# PWM Output Software Force Unit

This block sits on the path from a PWM action generator to the A and B outputs of one channel pair. It lets software override either output in two independent ways. The first is a one-shot force. Software flips a trigger bit, in either direction, and the output takes the selected level on the next clock. The generator takes the output back on its next action for that output.

The second is a continuous force, which holds an output low or high until software releases it. Software writes its setting into the configuration word. That setting acts as a shadow copy. It becomes active either at once or on a selectable mix of timer events: counter at zero, counter at period, compare A match, compare B match, and an external sync pulse. The update can also be frozen.

Software reaches the block through a single 16-bit write port. Outputs are combinational from internal state and the raw generator levels, so a pure pass-through adds no latency.

Top module: `pwm_swforce`

## Requirements
- R1: After reset the configuration word is zero, no force is in effect, and each output equals its raw generator input in the same cycle.
- R2: A one-shot mode value of 1 forces low and a value of 2 forces high. Values 0 and 3 are disabled, so a trigger toggle under them leaves the output unchanged.
- R3: Any change of a trigger bit, rising or falling, is one force event. The forced level appears one clock after the write edge that changed the bit. A write that keeps the bit's value causes no event.
- R4: A one-shot level holds until the generator action strobe for that output, after which the output follows the generator again. When a force event and an action strobe for the same output fall on one edge, the force wins (default).
- R5: An active continuous force (mode 1 low, mode 2 high, 0 and 3 off) overrides both the one-shot level and the generator. When it is released, a pending one-shot level shows again.
- R6: With update method 0, written continuous modes become active one clock after the write edge.
- R7: Update-method bits 0 to 4 enable the zero, period, compare A, compare B and sync events respectively. On an edge with any enabled event present, the active modes load from the shadow. Events that are not enabled do nothing.
- R8: When update-method bit 5 is set, the active continuous modes stay frozen whatever events occur.
- R9: The word layout is: update method [5:0], A continuous [7:6], B continuous [9:8], A trigger [10], A one-shot mode [12:11], B trigger [13], B one-shot mode [15:14].
- R10: The A and B paths are independent. A force on one never changes the other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | REG_W | Configuration word written when cfg_wr is high |
| gen_a | input | 1 | Raw generator level for output A |
| gen_b | input | 1 | Raw generator level for output B |
| gen_act_a | input | 1 | Generator applied an action to A this cycle |
| gen_act_b | input | 1 | Generator applied an action to B this cycle |
| ev_zero | input | 1 | Timer counter equals zero |
| ev_period | input | 1 | Timer counter equals period |
| ev_cmp_a | input | 1 | Timer counter equals compare A |
| ev_cmp_b | input | 1 | Timer counter equals compare B |
| sync_in | input | 1 | Sync pulse |
| pwm_a | output | 1 | Output A after forcing |
| pwm_b | output | 1 | Output B after forcing |

## Verification
The hardest case to reach from the ports is a one-shot force event and a generator action strobe for the same output on the same edge. The force event fires one clock after the write, so the stimulus writes the toggled trigger and then raises the action strobe in the very next cycle. A related hard case is a one-shot level hidden under a continuous force. The bench arms a one-shot while a continuous force is active, then releases the continuous force and expects the stored one-shot level rather than the generator. A behavioural model tracks every state bit from the port activity and is compared with both outputs on every clock.

// File: rtl/pwm_force_pkg.sv
package pwm_force_pkg;

   // Force mode encoding shared by one-shot and continuous fields
   typedef enum logic [1:0] {
      FM_OFF_0 = 2'd0,
      FM_LOW   = 2'd1,
      FM_HIGH  = 2'd2,
      FM_OFF_3 = 2'd3
   } fmode_e;

   // Field layout of the configuration word
   localparam int unsigned UPD_LSB    = 0;
   localparam int unsigned CONT_A_LSB = 6;
   localparam int unsigned CONT_B_LSB = 8;
   localparam int unsigned TRIG_A_BIT = 10;
   localparam int unsigned OSM_A_LSB  = 11;
   localparam int unsigned TRIG_B_BIT = 13;
   localparam int unsigned OSM_B_LSB  = 14;
   localparam int unsigned CFG_MIN_W  = 16;

   function automatic logic fm_on(input logic [1:0] m);
      return (m == FM_LOW) || (m == FM_HIGH);
   endfunction

   function automatic logic fm_level(input logic [1:0] m);
      return (m == FM_HIGH);
   endfunction

endpackage

// File: rtl/pfu_cfg_reg.sv
module pfu_cfg_reg #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] cfg_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_o <= '0;
      else if (wr_i) cfg_o <= wdata_i;
   end

endmodule

// File: rtl/pfu_cont_latch.sv
module pfu_cont_latch #(
   parameter int unsigned EVT_N = 5,
   parameter int unsigned CH_N  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EVT_N:0]       method_i,
   input  logic [CH_N-1:0][1:0] shadow_i,
   input  logic [EVT_N-1:0]     evt_i,
   output logic [CH_N-1:0][1:0] active_o
);

   logic immediate;
   logic freeze;
   logic evt_hit;
   logic load;

   assign immediate = (method_i == '0);
   assign freeze    = method_i[EVT_N];
   assign evt_hit   = |(method_i[EVT_N-1:0] & evt_i);
   assign load      = immediate | (~freeze & evt_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active_o <= '0;
      else if (load) active_o <= shadow_i;
   end

   // R8: frozen method keeps the active modes
   a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      method_i[EVT_N] |=> $stable(active_o));

   // R6: method zero loads the shadow on the next edge
   a_r6_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
      (method_i == '0) |=> (active_o == $past(shadow_i)));

   // R7: no enabled event, no update
   a_r7_no_event_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      ((method_i != '0) && ((method_i[EVT_N-1:0] & evt_i) == '0)) |=> $stable(active_o));

endmodule

// File: rtl/pfu_oneshot_chan.sv
module pfu_oneshot_chan
   import pwm_force_pkg::*;
#(
   parameter bit FORCE_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] osm_i,
   input  logic       trig_i,
   input  logic [1:0] cont_i,
   input  logic       gen_i,
   input  logic       act_i,
   output logic       out_o
);

   logic trig_d;
   logic hold_q;
   logic lvl_q;
   logic toggle;
   logic fire;
   logic set_en;
   logic clr_en;

   assign toggle = trig_i ^ trig_d;
   assign fire   = toggle & fm_on(osm_i);

   generate
      if (FORCE_WINS) begin : g_force_first
         assign set_en = fire;
         assign clr_en = act_i & ~fire;
      end else begin : g_action_first
         assign clr_en = act_i;
         assign set_en = fire & ~act_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_d <= 1'b0;
         hold_q <= 1'b0;
         lvl_q  <= 1'b0;
      end else begin
         trig_d <= trig_i;
         if (set_en) begin
            hold_q <= 1'b1;
            lvl_q  <= fm_level(osm_i);
         end else if (clr_en) begin
            hold_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (fm_on(cont_i)) out_o = fm_level(cont_i);
      else if (hold_q)   out_o = lvl_q;
      else               out_o = gen_i;
   end

   // R3: a low force event drives the output low on the next cycle
   a_r3_force_low_next: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (osm_i == FM_LOW) && (FORCE_WINS || !act_i)) |=> (fm_on(cont_i) || !out_o));

   // R2: a high force event drives the output high on the next cycle
   a_r2_force_high_next: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (osm_i == FM_HIGH) && (FORCE_WINS || !act_i)) |=> (fm_on(cont_i) || out_o));

   // R2: a toggle under a disabled mode leaves the one-shot state alone
   a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle && !fm_on(osm_i) && !act_i) |=> $stable(hold_q));

   // R4: a generator action without a force event hands the output back
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && !fire) |=> (fm_on(cont_i) || (out_o == gen_i)));

endmodule

// File: rtl/pwm_swforce.sv
module pwm_swforce
   import pwm_force_pkg::*;
#(
   parameter int unsigned REG_W      = 16,
   parameter bit          FORCE_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             gen_a,
   input  logic             gen_b,
   input  logic             gen_act_a,
   input  logic             gen_act_b,
   input  logic             ev_zero,
   input  logic             ev_period,
   input  logic             ev_cmp_a,
   input  logic             ev_cmp_b,
   input  logic             sync_in,
   output logic             pwm_a,
   output logic             pwm_b
);

   localparam int unsigned EVT_N = 5;
   localparam int unsigned CH_N  = 2;

   generate
      if (REG_W < CFG_MIN_W) begin : g_bad_width
         $error("pwm_swforce: REG_W must hold the whole configuration word");
      end
   endgenerate

   logic [REG_W-1:0]     cfg_q;
   logic [EVT_N-1:0]     evt;
   logic [CH_N-1:0][1:0] shadow;
   logic [CH_N-1:0][1:0] active;
   logic [CH_N-1:0]      gen_v;
   logic [CH_N-1:0]      act_v;
   logic [CH_N-1:0]      out_v;

   assign evt       = {sync_in, ev_cmp_b, ev_cmp_a, ev_period, ev_zero};
   assign shadow[0] = cfg_q[CONT_A_LSB +: 2];
   assign shadow[1] = cfg_q[CONT_B_LSB +: 2];
   assign gen_v     = {gen_b, gen_a};
   assign act_v     = {gen_act_b, gen_act_a};

   pfu_cfg_reg #(.REG_W(REG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr),
      .wdata_i (cfg_wdata),
      .cfg_o   (cfg_q)
   );

   pfu_cont_latch #(.EVT_N(EVT_N), .CH_N(CH_N)) u_cont (
      .clk      (clk),
      .rst_n    (rst_n),
      .method_i (cfg_q[UPD_LSB +: EVT_N+1]),
      .shadow_i (shadow),
      .evt_i    (evt),
      .active_o (active)
   );

   for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
      localparam int unsigned OSM_LSB  = (ch == 0) ? OSM_A_LSB : OSM_B_LSB;
      localparam int unsigned TRIG_POS = (ch == 0) ? TRIG_A_BIT : TRIG_B_BIT;

      pfu_oneshot_chan #(.FORCE_WINS(FORCE_WINS)) u_os (
         .clk    (clk),
         .rst_n  (rst_n),
         .osm_i  (cfg_q[OSM_LSB +: 2]),
         .trig_i (cfg_q[TRIG_POS]),
         .cont_i (active[ch]),
         .gen_i  (gen_v[ch]),
         .act_i  (act_v[ch]),
         .out_o  (out_v[ch])
      );
   end

   assign pwm_a = out_v[0];
   assign pwm_b = out_v[1];

   // R1: the cycle after reset releases, nothing is forced
   a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((pwm_a == gen_a) && (pwm_b == gen_b)));

   // R5: an active continuous low on A wins over everything
   a_r5_cont_low_a: assert property (@(posedge clk) disable iff (!rst_n)
      (active[0] == FM_LOW) |-> !pwm_a);

endmodule

// File: tb/pwm_swforce_tb_top.sv
`timescale 1ns/1ps
module pwm_swforce_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        gen_a = 1'b1, gen_b = 1'b0;
   logic        gen_act_a = 1'b0, gen_act_b = 1'b0;
   logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmp_a = 1'b0, ev_cmp_b = 1'b0, sync_in = 1'b0;
   logic        pwm_a, pwm_b;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwm_swforce dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .gen_a(gen_a), .gen_b(gen_b), .gen_act_a(gen_act_a), .gen_act_b(gen_act_b),
      .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b),
      .sync_in(sync_in), .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_reg = '0;
   bit          m_prev[2];
   bit          m_hold[2];
   bit          m_lvl[2];
   int          m_cont[2];

   function automatic int field(input logic [15:0] w, input int lsb, input int width);
      return int'((w >> lsb) & ((16'd1 << width) - 16'd1));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg = '0;
         for (int c = 0; c < 2; c++) begin
            m_prev[c] = 0; m_hold[c] = 0; m_lvl[c] = 0; m_cont[c] = 0;
         end
      end else begin
         int  meth;
         bit  upd;
         bit  ev_any;
         meth = field(m_reg, 0, 6);
         ev_any = (meth[0] && ev_zero) || (meth[1] && ev_period) || (meth[2] && ev_cmp_a)
               || (meth[3] && ev_cmp_b) || (meth[4] && sync_in);
         upd = (meth == 0) || (!meth[5] && ev_any);
         for (int c = 0; c < 2; c++) begin
            int  mode;
            bit  trig;
            bit  act;
            mode = field(m_reg, (c == 0) ? 11 : 14, 2);
            trig = m_reg[(c == 0) ? 10 : 13];
            act  = (c == 0) ? gen_act_a : gen_act_b;
            if (trig != m_prev[c] && (mode == 1 || mode == 2)) begin
               m_hold[c] = 1;
               m_lvl[c]  = (mode == 2);
            end else if (act) begin
               m_hold[c] = 0;
            end
            m_prev[c] = trig;
            if (upd) m_cont[c] = field(m_reg, (c == 0) ? 6 : 8, 2);
         end
         if (cfg_wr) m_reg = cfg_wdata;
      end
   end

   function automatic bit model_out(input int c, input bit g);
      if (m_cont[c] == 1) return 1'b0;
      if (m_cont[c] == 2) return 1'b1;
      if (m_hold[c]) return m_lvl[c];
      return g;
   endfunction

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         checks++;
         if (pwm_a !== model_out(0, gen_a) || pwm_b !== model_out(1, gen_b)) begin
            errors++;
            $display("FAIL model compare R10 at %0t: got a=%b b=%b expected a=%b b=%b",
                     $time, pwm_a, pwm_b, model_out(0, gen_a), model_out(1, gen_b));
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_ev(input int k);
      @(negedge clk);
      case (k)
         0: ev_zero = 1'b1;
         1: ev_period = 1'b1;
         2: ev_cmp_a = 1'b1;
         3: ev_cmp_b = 1'b1;
         default: sync_in = 1'b1;
      endcase
      @(negedge clk);
      ev_zero = 1'b0; ev_period = 1'b0; ev_cmp_a = 1'b0; ev_cmp_b = 1'b0; sync_in = 1'b0;
   endtask

   task automatic pulse_act(input int c);
      @(negedge clk);
      if (c == 0) gen_act_a = 1'b1; else gen_act_b = 1'b1;
      @(negedge clk);
      gen_act_a = 1'b0; gen_act_b = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 20000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   localparam logic [15:0] BASE = (16'd2 << 11) | (16'd1 << 10);

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 pass-through a", pwm_a, 1'b1);
      chk("R1 pass-through b", pwm_b, 1'b0);
      gen_a = 1'b0; step(1);
      chk("R1 follows gen", pwm_a, 1'b0);
      gen_a = 1'b1; gen_b = 1'b1; step(1);

      // one-shot low on A, rising trigger
      wr((16'd1 << 11) | (16'd1 << 10));
      chk("R3 not before next clock", pwm_a, 1'b1);
      step(1);
      chk("R2 forced low", pwm_a, 1'b0);
      chk("R10 B untouched", pwm_b, 1'b1);

      // hold survives gen changes until an action
      gen_a = 1'b0; step(1); gen_a = 1'b1; step(1);
      chk("R4 held without action", pwm_a, 1'b0);
      pulse_act(0);
      chk("R4 released by action", pwm_a, 1'b1);

      // falling trigger, force high
      gen_a = 1'b0; step(1);
      wr(16'd2 << 11); step(1);
      chk("R3 falling toggle", pwm_a, 1'b1);

      // same trigger value rewritten: no event
      gen_a = 1'b1; pulse_act(0);
      wr(16'd1 << 11); step(2);
      chk("R3 no toggle no event", pwm_a, 1'b1);

      // disabled modes 3 and 0
      wr((16'd3 << 11) | (16'd1 << 10)); step(2);
      chk("R2 mode 3 ignored", pwm_a, 1'b1);
      wr(16'd0); step(2);
      chk("R2 mode 0 ignored", pwm_a, 1'b1);

      // B one-shot high
      gen_b = 1'b0; step(1);
      wr((16'd2 << 14) | (16'd1 << 13)); step(1);
      chk("R9 B force high", pwm_b, 1'b1);
      chk("R10 A untouched", pwm_a, 1'b1);

      // force event and action on the same edge
      wr(16'd1 << 14);
      gen_act_b = 1'b1; gen_b = 1'b1;
      @(negedge clk);
      gen_act_b = 1'b0;
      chk("R4 force wins over action", pwm_b, 1'b0);
      step(2);
      chk("R4 still held", pwm_b, 1'b0);
      pulse_act(1);
      chk("R4 B released", pwm_b, 1'b1);

      // continuous immediate update
      wr(16'd1 << 6);
      chk("R6 not yet active", pwm_a, 1'b1);
      step(1);
      chk("R6 active next clock", pwm_a, 1'b0);
      gen_a = 1'b0;
      wr((16'd1 << 6) | BASE); step(2);
      chk("R5 continuous over one-shot", pwm_a, 1'b0);
      wr(BASE); step(1);
      chk("R5 one-shot shows after release", pwm_a, 1'b1);

      // event-selected updates on B
      gen_b = 1'b0;
      wr(BASE | (16'd2 << 8) | 16'h04); step(3);
      chk("R7 waits for event", pwm_b, 1'b0);
      pulse_ev(0);
      chk("R7 unselected event ignored", pwm_b, 1'b0);
      pulse_ev(2);
      chk("R7 compare A loads", pwm_b, 1'b1);
      wr(BASE | (16'd1 << 8) | 16'h10); step(2);
      pulse_ev(2);
      chk("R7 compare A no longer selected", pwm_b, 1'b1);
      pulse_ev(4);
      chk("R7 sync loads", pwm_b, 1'b0);
      wr(BASE | (16'd2 << 8) | 16'h21);
      pulse_ev(0);
      chk("R8 frozen on zero", pwm_b, 1'b0);
      pulse_ev(4);
      chk("R8 frozen on sync", pwm_b, 1'b0);
      wr(BASE | (16'd2 << 8) | 16'h01);
      pulse_ev(0);
      chk("R7 zero loads", pwm_b, 1'b1);
      wr(BASE | 16'h0A);
      pulse_ev(3);
      chk("R7 compare B of a multi-bit method", pwm_b, 1'b0);
      chk("R10 A keeps its one-shot", pwm_a, 1'b1);

      step(2);
      finish_run();
   end

endmodule